// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Controller

This block serves a bank of general-purpose pins. Each pin owns a 4 KiB register slot on a simple memory-mapped read/write bus. The slot holds three registers:

- **Data register.** It returns the synchronized input level and holds the output drive value.
- **Configuration register.** It selects how an interrupt event is recognized: level, rising edge, falling edge or both edges. It also holds the level polarity, whether raw events are latched, an interrupt enable and a routing target.
- **Status register.** It latches detected events until software clears it.

A pin contributes to the single summary interrupt only when all of the following hold:

- its status is pending;
- its enable is set;
- its routing target selects the summary line.

Software picks the detection mode per pin and clears status through the same bus. It typically reads each pin's status when the summary interrupt fires. The pin count is a parameter, and the address decode carries exactly enough index bits for it.

Top module: `gpio_irq_bank`

## Requirements
- R1: After a synchronous reset every register reads zero, every output drive is 0, the summary interrupt is 0 and read data is 0.
- R2: Pin p's registers sit at byte address p*0x1000 plus an offset: data at 0x4, configuration at 0x8, status at 0xC. A read returns its word on the read-data port one clock after the request; in cycles without a read the read-data port is zero.
- R3: In the data register, bit 0 reads the pin input after a two-flop synchronizer, and bit 1 holds the drive value. The drive value is written from write-data bit 1 and appears on the pin output one clock after the write.
- R4: Configuration bits [3:2] = 00 selects level detection. Polarity bit 1 chooses the active level: 1 is active-high and 0 is active-low. The status bit is set again on every cycle the synchronized input sits at the active level, so a clear does not stick while the level persists.
- R5: Configuration bits [3:2] select the edge modes: 01 is rising, 10 is falling and 11 is both. An edge is found by comparing the current synchronized sample with the previous one. The polarity bit has no effect in the edge modes.
- R6: Configuration bit 4 enables latching of detected events. With it at 0, status is never set.
- R7: Writing the status register with bit 0 = 0 clears it. Writing it with bit 0 = 1 leaves it unchanged. A detection in the same cycle as a clear wins.
- R8: The summary interrupt is the OR over all pins of (status AND configuration bit 0 AND configuration bits [7:5] = 3). It is registered, so it follows the status bit by one clock.
- R9: Reads of offsets other than 0x4, 0x8 and 0xC, and reads of pin indices at or above the pin count, return zero. Writes to them change nothing.
- R10: The configuration register stores write-data bits [7:0] and reads back with bits [31:8] as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Asynchronous pin input levels |
| pin_out | output | NUM_PINS | Registered pin drive values |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12+PIN_BITS | Byte address: pin index above bit 11, slot offset in bits [11:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, zero when no read |
| irq_out | output | 1 | Registered summary interrupt |

## Verification
Each result is due a fixed number of clock edges after its stimulus:

- **Pin input change.** It reaches data bit 0 after two edges, the status bit after a third edge, and the summary interrupt after a fourth.
- **Register write.** It takes effect at the next edge.
- **Read.** Its data appears one edge after the request.

The bench steps a behavioural model once per rising edge and compares the pin outputs, the summary interrupt and the read data at every falling edge. Its directed reads of fixed expected values wait at least five edges after any pin change, so every pipeline stage has settled before sampling.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int          SLOT_BITS     = 12;
  localparam logic [11:0] OFS_DATA      = 12'h004;
  localparam logic [11:0] OFS_CFG       = 12'h008;
  localparam logic [11:0] OFS_STAT      = 12'h00C;
  localparam logic [2:0]  ROUTE_SUMMARY = 3'd3;

  typedef enum logic [1:0] {
    DET_LEVEL = 2'b00,
    DET_RISE  = 2'b01,
    DET_FALL  = 2'b10,
    DET_BOTH  = 2'b11
  } det_mode_e;

  // Packed MSB first: target [7:5], latch enable [4], mode [3:2], polarity [1], irq enable [0]
  typedef struct packed {
    logic [2:0] target;
    logic       raw_en;
    det_mode_e  mode;
    logic       pol;
    logic       irq_en;
  } pin_cfg_t;
endpackage

// File: rtl/gpio_sync_bank.sv
module gpio_sync_bank #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/gpio_pin_slot.sv
module gpio_pin_slot
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       level_in,
  input  logic       wr_data,
  input  logic       wr_cfg,
  input  logic       wr_stat,
  input  logic [7:0] wdata,
  output logic       drive_q,
  output pin_cfg_t   cfg_q,
  output logic       status_q,
  output logic       irq_req
);
  logic prev_q;
  logic hit;

  always_comb begin
    hit = 1'b0;
    case (cfg_q.mode)
      DET_LEVEL: hit = (level_in == cfg_q.pol);
      DET_RISE:  hit = level_in & ~prev_q;
      DET_FALL:  hit = ~level_in & prev_q;
      DET_BOTH:  hit = level_in ^ prev_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      drive_q  <= 1'b0;
      cfg_q    <= '0;
      status_q <= 1'b0;
    end else begin
      prev_q <= level_in;
      if (wr_data) drive_q <= wdata[1];
      if (wr_cfg)  cfg_q   <= pin_cfg_t'(wdata);
      if (cfg_q.raw_en && hit)       status_q <= 1'b1;
      else if (wr_stat && !wdata[0]) status_q <= 1'b0;
    end
  end

  assign irq_req = status_q & cfg_q.irq_en & (cfg_q.target == ROUTE_SUMMARY);

  assert_latch_gate_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q) |-> $past(cfg_q.raw_en));
  assert_clear_source_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(status_q) |-> $past(wr_stat));
  assert_level_relatch_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.mode == DET_LEVEL && cfg_q.raw_en && level_in == cfg_q.pol) |=> status_q);
  assert_rise_latch_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.mode == DET_RISE && cfg_q.raw_en && level_in && !prev_q) |=> status_q);
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic         irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |req;
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 6,
  parameter int SYNC_STAGES = 2,
  localparam int PIN_BITS   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int ADDR_W     = SLOT_BITS + PIN_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                irq_out
);
  logic [PIN_BITS-1:0]  pin_idx;
  logic [11:0]          ofs;
  logic                 idx_ok;
  logic [NUM_PINS-1:0]  sync_v, drive_v, stat_v, req_v;
  pin_cfg_t             cfg_v [NUM_PINS];
  logic [31:0]          rd_word;
  logic                 unused_wdata;

  assign pin_idx      = bus_addr[ADDR_W-1:SLOT_BITS];
  assign ofs          = bus_addr[SLOT_BITS-1:0];
  assign idx_ok       = (32'(pin_idx) < NUM_PINS);
  assign unused_wdata = ^bus_wdata[31:8];

  gpio_sync_bank #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(sync_v)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic hit_p;
    assign hit_p = bus_sel && bus_wr && idx_ok && (pin_idx == PIN_BITS'(p));
    gpio_pin_slot u_slot (
      .clk      (clk),
      .rst      (rst),
      .level_in (sync_v[p]),
      .wr_data  (hit_p && ofs == OFS_DATA),
      .wr_cfg   (hit_p && ofs == OFS_CFG),
      .wr_stat  (hit_p && ofs == OFS_STAT),
      .wdata    (bus_wdata[7:0]),
      .drive_q  (drive_v[p]),
      .cfg_q    (cfg_v[p]),
      .status_q (stat_v[p]),
      .irq_req  (req_v[p])
    );
  end

  always_comb begin
    rd_word = '0;
    if (idx_ok) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (pin_idx == PIN_BITS'(p)) begin
          case (ofs)
            OFS_DATA: rd_word = {30'b0, drive_v[p], sync_v[p]};
            OFS_CFG:  rd_word = {24'b0, cfg_v[p]};
            OFS_STAT: rd_word = {31'b0, stat_v[p]};
            default:  rd_word = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_word;
    else                       bus_rdata <= '0;
  end

  gpio_irq_merge #(.N(NUM_PINS)) u_merge (
    .clk(clk), .rst(rst), .req(req_v), .irq_q(irq_out)
  );

  assign pin_out = drive_v;

  assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (rst)
    $past(bus_sel && !bus_wr && !idx_ok) |-> (bus_rdata == '0));
  assert_irq_source_R8: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(|stat_v));
endmodule

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
  localparam int N  = 6;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  pins = '0;
  logic [N-1:0]  pin_out;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_out;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  gpio_irq_bank #(.NUM_PINS(N)) uut (
    .clk(clk), .rst(rst), .pin_in(pins), .pin_out(pin_out),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  bit       m_s1 [N], m_cur [N], m_prev [N], m_out [N], m_st [N];
  bit [7:0] m_cfg [N];
  bit       m_irq;
  bit [31:0] m_rd;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_s1[i]) begin
        m_s1[i] = 0; m_cur[i] = 0; m_prev[i] = 0; m_out[i] = 0; m_st[i] = 0; m_cfg[i] = 0;
      end
      m_irq = 0; m_rd = 0;
    end else begin
      int idx;
      int ofs;
      bit irq_n;
      bit [31:0] rd_n;
      idx = int'(bus_addr) / 4096;
      ofs = int'(bus_addr) % 4096;
      rd_n = 0;
      if (bus_sel && !bus_wr && idx < N) begin
        if (ofs == 4)       rd_n = {30'd0, m_out[idx], m_cur[idx]};
        else if (ofs == 8)  rd_n = {24'd0, m_cfg[idx]};
        else if (ofs == 12) rd_n = {31'd0, m_st[idx]};
      end
      irq_n = 0;
      for (int p = 0; p < N; p++)
        if (m_st[p] && m_cfg[p][0] && m_cfg[p][7:5] == 3) irq_n = 1;
      for (int p = 0; p < N; p++) begin
        bit ev;
        case (m_cfg[p][3:2])
          0: ev = (m_cur[p] == m_cfg[p][1]);
          1: ev = m_cur[p] && !m_prev[p];
          2: ev = !m_cur[p] && m_prev[p];
          default: ev = m_cur[p] != m_prev[p];
        endcase
        if (m_cfg[p][4] && ev) m_st[p] = 1;
        else if (bus_sel && bus_wr && idx == p && ofs == 12 && !bus_wdata[0]) m_st[p] = 0;
        if (bus_sel && bus_wr && idx == p && ofs == 4) m_out[p] = bus_wdata[1];
        if (bus_sel && bus_wr && idx == p && ofs == 8) m_cfg[p] = bus_wdata[7:0];
        m_prev[p] = m_cur[p];
        m_cur[p] = m_s1[p];
        m_s1[p] = pins[p];
      end
      m_irq = irq_n;
      m_rd = rd_n;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [N-1:0] mo;
      for (int p = 0; p < N; p++) mo[p] = m_out[p];
      check(pin_out == mo, "R3 pin_out model", 32'(pin_out), 32'(mo));
      check(irq_out == m_irq, "R8 irq model", 32'(irq_out), 32'(m_irq));
      check(bus_rdata == m_rd, "R2 rdata model", bus_rdata, m_rd);
    end
  end

  function automatic logic [AW-1:0] A(input int pin, input int ofs);
    return AW'(pin * 4096 + ofs);
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); check(bus_rdata == exp, req, bus_rdata, exp); bus_sel = 0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #2000000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check(irq_out == 0, "R1 irq after reset", 32'(irq_out), 0);
    check(pin_out == 0, "R1 pin_out after reset", 32'(pin_out), 0);
    rd(A(0, 8), 0, "R1 cfg reset");
    rd(A(3, 12), 0, "R1 status reset");
    // R3 data register
    wr(A(1, 4), 32'h2);
    check(pin_out == 6'b000010, "R3 drive bit", 32'(pin_out), 32'h2);
    rd(A(1, 4), 32'h2, "R3 data readback");
    pins[2] = 1; pins[1] = 1; settle();
    rd(A(2, 4), 32'h1, "R3 input level");
    rd(A(1, 4), 32'h3, "R3 input and drive");
    // R10 configuration width
    wr(A(5, 8), 32'hABCD_1234);
    rd(A(5, 8), 32'h34, "R10 cfg readback");
    // R4 level active-high, routed
    wr(A(0, 8), 32'h73);
    pins[0] = 1; settle();
    rd(A(0, 12), 1, "R4 level high latch");
    check(irq_out == 1, "R8 irq level", 32'(irq_out), 1);
    wr(A(0, 12), 0); settle();
    rd(A(0, 12), 1, "R4 relatch while active");
    pins[0] = 0; settle();
    wr(A(0, 12), 0); settle();
    rd(A(0, 12), 0, "R7 clear after inactive");
    check(irq_out == 0, "R8 irq drops", 32'(irq_out), 0);
    wr(A(0, 12), 1); settle();
    rd(A(0, 12), 0, "R7 write one no set");
    // R4 level active-low
    wr(A(3, 8), 32'h71); settle();
    rd(A(3, 12), 1, "R4 level low latch");
    pins[3] = 1; settle();
    wr(A(3, 12), 0); settle();
    rd(A(3, 12), 0, "R4 level low inactive");
    // R5 rising
    wr(A(4, 8), 32'h77); settle();
    rd(A(4, 12), 0, "R5 rising idle");
    pins[4] = 1; settle();
    rd(A(4, 12), 1, "R5 rising edge");
    wr(A(4, 12), 0); settle();
    rd(A(4, 12), 0, "R5 held high no relatch");
    pins[4] = 0; settle();
    rd(A(4, 12), 0, "R5 rising ignores fall");
    // R5 falling
    wr(A(5, 8), 32'h7B);
    pins[5] = 1; settle();
    rd(A(5, 12), 0, "R5 falling ignores rise");
    pins[5] = 0; settle();
    rd(A(5, 12), 1, "R5 falling edge");
    wr(A(5, 12), 0);
    // R5 both edges
    wr(A(4, 8), 32'h7D);
    pins[4] = 1; settle();
    rd(A(4, 12), 1, "R5 both rise");
    wr(A(4, 12), 0);
    pins[4] = 0; settle();
    rd(A(4, 12), 1, "R5 both fall");
    wr(A(4, 12), 0);
    // R5 polarity ignored in edge mode
    wr(A(4, 8), 32'h75);
    pins[4] = 1; settle();
    rd(A(4, 12), 1, "R5 rising with pol 0");
    wr(A(4, 8), 0); wr(A(4, 12), 0);
    pins[4] = 0;
    // R6 latch disabled
    wr(A(2, 8), 32'h6D);
    pins[2] = 0; settle();
    pins[2] = 1; settle();
    rd(A(2, 12), 0, "R6 no latch without enable");
    check(irq_out == 0, "R6 irq quiet", 32'(irq_out), 0);
    // R8 routing and enable
    wr(A(1, 8), 32'h53); settle();
    rd(A(1, 12), 1, "R8 status other target");
    check(irq_out == 0, "R8 target 2 blocked", 32'(irq_out), 0);
    wr(A(1, 8), 32'h73); settle();
    check(irq_out == 1, "R8 target 3 routed", 32'(irq_out), 1);
    wr(A(1, 8), 32'h72); settle();
    check(irq_out == 0, "R8 enable off", 32'(irq_out), 0);
    wr(A(1, 8), 0); wr(A(1, 12), 0); pins[1] = 0; settle();
    // R9 unmapped
    rd(A(6, 8), 0, "R9 pin beyond count");
    wr(A(7, 8), 32'hFF);
    rd(A(7, 8), 0, "R9 write beyond count");
    wr(A(0, 0), 32'hFF);
    rd(A(0, 8), 32'h73, "R9 unmapped write ignored");
    rd(A(0, 16), 0, "R9 unmapped offset");
    check(pin_out == 6'b000010, "R9 drive unchanged", 32'(pin_out), 32'h2);
    settle();
    finish_run();
  end
endmodule